// File: doc/BRIEF.md
# Serial Programming Flash Address and Write Controller

This block is the target-side engine behind a serial programming port. Commands arrive already decoded as a 4-bit operation code with a 14-bit data word on a valid/ready stream. The block keeps a forward-only word address over a 16K-word space. The lower half of that space is user program memory and the upper half is configuration memory. It collects up to four words in a row latch and commits them when a programming cycle begins. The cycle is timed from outside and closed by an explicit end command.

The block also runs an internally timed bulk erase whose reach depends on which half the address points at, and applies code protection to program memory. Read data returns on a second valid/ready stream. Both the user array (2K words by default) and the eight configuration words are held in registers. A `mode_enter` pulse stands for a fresh entry into programming mode. A stalled read response back-pressures the command stream: `cmd_ready` is low while `rsp_valid` is high and `rsp_ready` has not yet taken it. `rsp_data` holds steady until the response is accepted.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After `rst_n` low or a `mode_enter` pulse, the address is 0x0000, every row slot is unloaded and holds 0x3FFF, and `busy` is low. `rst_n` additionally sets every array word to the erased value 0x3FFF.
- R2: An increment adds one to the low 13 address bits and keeps bit 13. The user half wraps from 0x1FFF to 0x0000, and the configuration half wraps from 0x3FFF to 0x2000.
- R3: A load-configuration command sets the address to 0x2000 and stores its data in row slot 0. Only `mode_enter` or reset brings the address back to the user half.
- R4: A load-data command stores its word in row slot address[1:0] and marks it loaded. A begin command writes each loaded slot s to address {address[13:2], s} as old AND new, with no erase. Slots left unloaded leave their words untouched.
- R5: User addresses select array word address modulo the user array size (0x800 by default). Address bits above that are ignored.
- R6: In the configuration half, 0x2000–0x2003 are ID words programmed by AND. 0x2006 reads the DEV_ID parameter and ignores writes. 0x2004, 0x2005 and 0x2008–0x3FFF read 0 and ignore writes. 0x2007 is the configuration word: a write replaces bits 12..0 outright, while bit 13 can only be cleared.
- R7: An end command clears every loaded flag, sets all row slots to 0x3FFF and drops `busy`.
- R8: `busy` is high from an accepted begin until an accepted end, and for exactly ERASE_CYCLES cycles after an accepted erase. While programming, every command except end is dropped. While erasing, every command is dropped. A dropped command raises `cmd_err` for one cycle, one cycle after acceptance.
- R9: Bulk erase with address bit 13 set erases user memory, the ID words and the configuration word. With bit 13 clear it erases user memory and the configuration word, and the IDs keep their values. Erase is the only way to set configuration bit 13 back to 1.
- R10: While configuration bit 13 is 0, user-half reads return 0 and user-half writes are blocked. ID and configuration-word reads and writes are unaffected.
- R11: A read command returns the word at the current address on `rsp_data` with `rsp_valid` the next cycle. `rsp_valid` and `rsp_data` hold until `rsp_ready`, and `cmd_ready` is low meanwhile.
- R12: Operation codes are 0 load-configuration, 1 load-data, 2 read, 3 increment, 4 begin, 5 end and 6 bulk erase. Codes 7–15 are dropped with `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also erases the array |
| mode_enter | input | 1 | Programming-mode entry pulse |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_code | input | 4 | Operation code |
| cmd_data | input | 14 | Data word for load commands |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 14 | Read response word |
| busy | output | 1 | Programming or erase in progress |
| cmd_err | output | 1 | One-cycle pulse for a dropped command |

## Verification
A wrong address register shows only through the next read, so the sweeps read back every user word and walk both halves across their wrap points. A mis-wrap then returns the wrong word on the first read after the boundary. A slot-decoding or loaded-flag fault corrupts neighbouring words of the row, and the fault appears in the full read-back after mode re-entry. A stuck busy or erase counter shows within ERASE_CYCLES cycles: the busy window comes out the wrong length, or a command that should be dropped produces no `cmd_err` pulse one cycle after it.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;
  localparam int WORD_W  = 14;
  localparam int PC_W    = 14;
  localparam int ROW_W   = 4;
  localparam int SLOT_AW = 2;
  localparam int CFG_AW  = 3;
  localparam int CP_BIT  = WORD_W - 1;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t ERASED = '1;
  localparam logic [PC_W-1:0] CFG_BASE = 14'h2000;

  typedef enum logic [3:0] {
    OP_LDCFG  = 4'd0,
    OP_LDDATA = 4'd1,
    OP_READ   = 4'd2,
    OP_INC    = 4'd3,
    OP_BEGIN  = 4'd4,
    OP_END    = 4'd5,
    OP_ERASE  = 4'd6
  } op_e;

  localparam logic [3:0] OP_LAST = 4'd6;
endpackage

// File: rtl/nvm_pc_ctr.sv
module nvm_pc_ctr
  import nvm_prog_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter_i,
  input  logic            inc_i,
  input  logic            ldcfg_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= '0;
    else if (enter_i) pc_q <= '0;
    else if (ldcfg_i) pc_q <= CFG_BASE;
    else if (inc_i)   pc_q <= {pc_q[PC_W-1], pc_q[PC_W-2:0] + 1'b1};
  end

  assign pc_o = pc_q;

  a_r1_enter_clears: assert property (@(posedge clk) disable iff (!rst_n)
    enter_i |=> (pc_q == '0));

  a_r2_step_in_half: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !enter_i && !ldcfg_i) |=>
      (pc_q == {$past(pc_q[PC_W-1]), $past(pc_q[PC_W-2:0]) + 1'b1}));

  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q[PC_W-1] && !enter_i) |=> pc_q[PC_W-1]);

  a_r3_cfg_base: assert property (@(posedge clk) disable iff (!rst_n)
    (ldcfg_i && !enter_i) |=> (pc_q == CFG_BASE));
endmodule

// File: rtl/nvm_row_latch.sv
module nvm_row_latch
  import nvm_prog_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          ld_i,
  input  logic [SLOT_AW-1:0]            slot_i,
  input  word_t                         data_i,
  output logic [ROW_W-1:0][WORD_W-1:0]  words_o,
  output logic [ROW_W-1:0]              loaded_o
);
  for (genvar g = 0; g < ROW_W; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
        words_o[g]  <= ERASED;
        loaded_o[g] <= 1'b0;
      end else if (ld_i && (slot_i == SLOT_AW'(g))) begin
        words_o[g]  <= data_i;
        loaded_o[g] <= 1'b1;
      end
    end
  end

  a_r7_clear_row: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (loaded_o == '0) && (words_o[0] == ERASED));

  a_r4_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && !clr_i) |=> ($countones(loaded_o ^ $past(loaded_o)) <= 1));
endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvm_prog_pkg::*;
#(
  parameter int    USER_AW = 11,
  parameter word_t DEV_ID  = 14'h0A35
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic [PC_W-3:0]               row_i,
  input  logic [ROW_W-1:0][WORD_W-1:0]  wdata_i,
  input  logic [ROW_W-1:0]              wmask_i,
  input  logic                          erase_i,
  input  logic                          erase_ids_i,
  input  logic [PC_W-1:0]               rd_addr_i,
  output word_t                         rd_data_o
);
  localparam int USER_WORDS = 1 << USER_AW;
  localparam int NUM_IDS    = 4;

  word_t umem [USER_WORDS];
  word_t ids  [NUM_IDS];
  word_t cfgw;

  logic               user_row, cfg_row;
  logic [USER_AW-1:0] uidx [ROW_W];

  assign user_row = !row_i[PC_W-3];
  assign cfg_row  = row_i[PC_W-3] && (row_i[PC_W-4:1] == '0);

  always_comb begin
    for (int s = 0; s < ROW_W; s++) begin
      uidx[s] = {row_i[USER_AW-3:0], SLOT_AW'(s)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < USER_WORDS; i++) umem[i] <= ERASED;
      for (int i = 0; i < NUM_IDS; i++)    ids[i]  <= ERASED;
      cfgw <= ERASED;
    end else if (erase_i) begin
      for (int i = 0; i < USER_WORDS; i++) umem[i] <= ERASED;
      if (erase_ids_i) begin
        for (int i = 0; i < NUM_IDS; i++) ids[i] <= ERASED;
      end
      cfgw <= ERASED;
    end else if (wr_i) begin
      for (int s = 0; s < ROW_W; s++) begin
        if (wmask_i[s]) begin
          if (user_row) begin
            if (cfgw[CP_BIT]) umem[uidx[s]] <= umem[uidx[s]] & wdata_i[s];
          end else if (cfg_row) begin
            if (!row_i[0]) begin
              ids[s] <= ids[s] & wdata_i[s];
            end else if (s == ROW_W - 1) begin
              cfgw <= {cfgw[CP_BIT] & wdata_i[s][CP_BIT], wdata_i[s][CP_BIT-1:0]};
            end
          end
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (!rd_addr_i[PC_W-1]) begin
      if (cfgw[CP_BIT]) rd_data_o = umem[rd_addr_i[USER_AW-1:0]];
    end else if (rd_addr_i[PC_W-2:CFG_AW] == '0) begin
      case (rd_addr_i[CFG_AW-1:0])
        3'd0, 3'd1, 3'd2, 3'd3: rd_data_o = ids[rd_addr_i[1:0]];
        3'd6:                   rd_data_o = DEV_ID;
        3'd7:                   rd_data_o = cfgw;
        default:                rd_data_o = '0;
      endcase
    end
  end

  a_r9_cp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgw[CP_BIT] && !erase_i) |=> !cfgw[CP_BIT]);

  a_r10_user_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgw[CP_BIT] && !rd_addr_i[PC_W-1]) |-> (rd_data_o == '0));

  a_r9_erase_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> (cfgw == ERASED));
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
  import nvm_prog_pkg::*;
#(
  parameter int    USER_AW      = 11,
  parameter int    ERASE_CYCLES = 16,
  parameter word_t DEV_ID       = 14'h0A35
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_enter,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [3:0]  cmd_code,
  input  logic [13:0] cmd_data,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [13:0] rsp_data,
  output logic        busy,
  output logic        cmd_err
);
  localparam int ECW = $clog2(ERASE_CYCLES + 1);

  op_e                          op;
  logic                         fire, legal, blocked, take, erasing, prog_q;
  logic [ECW-1:0]               ers_cnt;
  logic [PC_W-1:0]              pc;
  logic [ROW_W-1:0][WORD_W-1:0] row_words;
  logic [ROW_W-1:0]             row_loaded;
  word_t                        rd_word;

  assign op        = op_e'(cmd_code);
  assign cmd_ready = !rsp_valid;
  assign fire      = cmd_valid && cmd_ready;
  assign legal     = (cmd_code <= OP_LAST);
  assign erasing   = (ers_cnt != '0);
  assign blocked   = erasing || (prog_q && (op != OP_END));
  assign take      = fire && legal && !blocked;
  assign busy      = prog_q || erasing;

  nvm_pc_ctr u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .enter_i (mode_enter),
    .inc_i   (take && (op == OP_INC)),
    .ldcfg_i (take && (op == OP_LDCFG)),
    .pc_o    (pc)
  );

  nvm_row_latch u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (mode_enter || (take && (op == OP_END))),
    .ld_i     (take && ((op == OP_LDDATA) || (op == OP_LDCFG))),
    .slot_i   ((op == OP_LDCFG) ? SLOT_AW'(0) : pc[SLOT_AW-1:0]),
    .data_i   (cmd_data),
    .words_o  (row_words),
    .loaded_o (row_loaded)
  );

  nvm_array #(.USER_AW(USER_AW), .DEV_ID(DEV_ID)) u_arr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (take && (op == OP_BEGIN)),
    .row_i       (pc[PC_W-1:SLOT_AW]),
    .wdata_i     (row_words),
    .wmask_i     (row_loaded),
    .erase_i     (take && (op == OP_ERASE)),
    .erase_ids_i (pc[PC_W-1]),
    .rd_addr_i   (pc),
    .rd_data_o   (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q  <= 1'b0;
      ers_cnt <= '0;
      cmd_err <= 1'b0;
    end else begin
      cmd_err <= fire && !take;
      if (mode_enter) begin
        prog_q  <= 1'b0;
        ers_cnt <= '0;
      end else begin
        if (take && (op == OP_BEGIN))    prog_q <= 1'b1;
        else if (take && (op == OP_END)) prog_q <= 1'b0;
        if (take && (op == OP_ERASE)) ers_cnt <= ECW'(ERASE_CYCLES);
        else if (erasing)             ers_cnt <= ers_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take && (op == OP_READ)) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r8_drop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && erasing) |=> cmd_err);

  a_r8_end_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op == OP_END)) |=> !busy);

  a_r8_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op == OP_ERASE) && !mode_enter) |=> busy);

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r12_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (cmd_code > OP_LAST)) |=> cmd_err);
endmodule

// File: tb/nvm_prog_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_prog_ctrl_tb;
  localparam int UAW   = 6;
  localparam int UW    = 1 << UAW;
  localparam int ECYC  = 8;
  localparam logic [13:0] DEVID = 14'h1A5C;

  logic clk = 0, rst_n = 0, mode_enter = 0, cmd_valid = 0, rsp_ready = 0;
  logic [3:0]  cmd_code = 0;
  logic [13:0] cmd_data = 0;
  logic cmd_ready, rsp_valid, busy, cmd_err;
  logic [13:0] rsp_data;

  int n_chk = 0, n_fail = 0;
  logic last_err;
  logic [13:0] ref_u [UW];
  logic [13:0] ref_id [4];
  logic [13:0] v, v2;

  always #2.5 clk = ~clk;

  nvm_prog_ctrl #(.USER_AW(UAW), .ERASE_CYCLES(ECYC), .DEV_ID(DEVID)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .cmd_err(cmd_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] c, input logic [13:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_code = c; cmd_data = d; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    last_err = cmd_err;
  endtask

  task automatic rd(output logic [13:0] val);
    send(4'd2, 14'h0);
    val = rsp_data;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic incn(input int n);
    for (int k = 0; k < n; k++) send(4'd3, 14'h0);
  endtask

  task automatic enter();
    @(negedge clk); mode_enter = 1;
    @(negedge clk); mode_enter = 0;
  endtask

  task automatic prog();
    send(4'd4, 14'h0);
    send(4'd5, 14'h0);
  endtask

  function automatic logic [13:0] pat(input int i);
    return 14'((i * 613 + 341) & 16'h3FFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    rd(v); chk("R1 erased word0", v, 14'h3FFF);

    // R4 four-word rows over the whole user array
    for (int r = 0; r < UW / 4; r++) begin
      for (int s = 0; s < 4; s++) begin
        send(4'd1, pat(4 * r + s));
        ref_u[4 * r + s] = pat(4 * r + s);
        if (s < 3) send(4'd3, 0);
      end
      send(4'd4, 0);
      if (r == 0) chk("R8 busy after begin", busy, 1);
      send(4'd5, 0);
      if (r == 0) chk("R7 busy after end", busy, 0);
      send(4'd3, 0);
    end
    enter();
    for (int i = 0; i < UW; i++) begin
      rd(v); chk($sformatf("R4 readback %0d", i), v, ref_u[i]);
      send(4'd3, 0);
    end
    rd(v); chk("R5 modulo alias", v, ref_u[0]);

    // R4 no pre-erase: AND of old and new
    enter();
    send(4'd1, 14'h2AAA); prog();
    ref_u[0] = ref_u[0] & 14'h2AAA;
    rd(v); chk("R4 and-program", v, ref_u[0]);

    // R4 unloaded slots untouched
    enter(); incn(6);
    send(4'd1, 14'h0); prog(); ref_u[6] = 14'h0;
    enter(); incn(4);
    for (int i = 4; i < 8; i++) begin
      rd(v); chk($sformatf("R4 partial row %0d", i), v, ref_u[i]);
      send(4'd3, 0);
    end

    // R7 end discards loaded words
    enter();
    send(4'd1, 14'h0); send(4'd5, 0); prog();
    rd(v); chk("R7 latch dropped", v, ref_u[0]);

    // R8 drop while programming, R12 illegal code
    enter();
    send(4'd4, 0);
    send(4'd3, 0); chk("R8 inc rejected", last_err, 1);
    send(4'd2, 0); chk("R8 read rejected", last_err, 1);
    chk("R8 no response", rsp_valid, 0);
    send(4'd5, 0); chk("R8 end accepted", last_err, 0);
    rd(v); chk("R8 pc unchanged", v, ref_u[0]);
    send(4'd9, 0); chk("R12 code 9 rejected", last_err, 1);
    send(4'd15, 0); chk("R12 code 15 rejected", last_err, 1);

    // R2 user wrap
    enter(); incn(14'h1FFF);
    rd(v); chk("R2 at 0x1FFF", v, ref_u[UW - 1]);
    send(4'd3, 0);
    rd(v); chk("R2 user wrap", v, ref_u[0]);

    // R3/R6 configuration half
    enter();
    ref_id[0] = 14'h0011; ref_id[1] = 14'h0022; ref_id[2] = 14'h0033; ref_id[3] = 14'h0044;
    send(4'd0, ref_id[0]);
    for (int i = 1; i < 4; i++) begin send(4'd3, 0); send(4'd1, ref_id[i]); end
    prog();
    enter(); send(4'd0, 14'h3FFF);
    for (int i = 0; i < 4; i++) begin
      rd(v); chk($sformatf("R6 id %0d", i), v, ref_id[i]); send(4'd3, 0);
    end
    rd(v); chk("R6 reserved 4", v, 0); send(4'd3, 0);
    rd(v); chk("R6 reserved 5", v, 0); send(4'd3, 0);
    rd(v); chk("R6 device id", v, DEVID); send(4'd3, 0);
    rd(v); chk("R6 cfg erased", v, 14'h3FFF);
    incn(14'h3FFF - 14'h2007);
    rd(v); chk("R6 unimplemented 0x3FFF", v, 0);
    send(4'd3, 0);
    rd(v); chk("R2 config wrap", v, ref_id[0]);
    enter();
    rd(v); chk("R3 back to user", v, ref_u[0]);

    // R6 writes to reserved/device id ignored
    enter(); send(4'd0, 14'h3FFF); incn(4);
    send(4'd1, 14'h0); incn(2); send(4'd1, 14'h0); prog();
    rd(v); chk("R6 device id kept", v, DEVID);

    // R6 cfg word rewrite, R9 CP sticky
    send(4'd3, 0);
    send(4'd1, 14'h3F0F); prog();
    send(4'd1, 14'h3FF0); prog();
    rd(v); chk("R6 cfg rewrite", v, 14'h3FF0);
    send(4'd1, 14'h1FF3); prog();
    rd(v); chk("R6 cp clear", v, 14'h1FF3);
    send(4'd1, 14'h3FFF); prog();
    rd(v); chk("R9 cp sticky", v, 14'h1FFF);

    // R10 protection
    enter();
    rd(v); chk("R10 user hidden 0", v, 0);
    send(4'd1, 14'h0); prog();
    incn(5); rd(v); chk("R10 user hidden 5", v, 0);
    enter(); send(4'd0, 14'h3FFF);
    rd(v); chk("R10 id visible", v, ref_id[0]);
    send(4'd1, 14'h0001); prog(); ref_id[0] = ref_id[0] & 14'h0001;
    rd(v); chk("R10 id writable", v, ref_id[0]);

    // R9 user-half erase, R8 erase drop
    enter();
    send(4'd6, 0);
    send(4'd3, 0); chk("R8 inc during erase", last_err, 1);
    while (busy) @(negedge clk);
    rd(v); chk("R9 user erased", v, 14'h3FFF);
    rd(v2); chk("R8 inc ignored in erase", v2, 14'h3FFF);
    enter(); send(4'd0, 14'h3FFF);
    rd(v); chk("R9 ids kept", v, ref_id[0]);
    incn(7); rd(v); chk("R9 cfg erased", v, 14'h3FFF);

    // R9 config-half erase, R8 erase length
    send(4'd6, 0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R8 erase length", n, ECYC);
    enter(); send(4'd0, 14'h3FFF); prog();
    rd(v); chk("R9 ids erased", v, 14'h3FFF);

    // R11 response back-pressure
    send(4'd3, 0); send(4'd1, 14'h0555); prog();
    send(4'd2, 0);
    v = rsp_data;
    repeat (3) @(negedge clk);
    chk("R11 valid held", rsp_valid, 1);
    chk("R11 data held", rsp_data, v);
    chk("R11 ready low", cmd_ready, 0);
    chk("R11 data value", v, 14'h0555);
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
    chk("R11 released", rsp_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule